// File: doc/BRIEF.md
# Multi-Sector Erase Queue Controller

This controller runs on the host side of a parallel flash part, after the host has already issued an initial sector-erase command. It appends more sectors to the erase job, one data cycle per sector, while the part's erase-window timer is still open. Generating the unlock cycles and polling for completion are left to other logic. This block only covers the window in which the part still takes more sectors.

After a start strobe, the controller first reads status to confirm that the initial command was taken. Either the polling bit reads low, or the toggle bit changes between two reads. For each queued sector it then reads the timer bit, writes the erase-confirm byte to the sector address, and reads the timer bit again. If the timer is already set before a write, the queue stops quietly. If the timer is set right after a write, that write may have been dropped, so the controller raises an error flag. Every transfer goes through a simple request/acknowledge bus master port. The result is a per-sector accepted mask and a one-cycle done pulse.

Top module: `mse_erase_queue`

## Requirements
- R1: While reset is held and just after it, busy, done, bus request, error flag and the whole accepted mask are all low.
- R2: A start with a sector count of zero makes no bus transfer, leaves the mask clear and the error low, and pulses done.
- R3: The first transfer after a start with a nonzero count is a status read. If bit 7 of the returned byte is 0, the controller moves to the sector loop without a second confirmation read.
- R4: If bit 7 was 1, a second status read follows. The loop is entered only if bit 6 differs between the two reads. Otherwise the error flag is set, no write is made, and done pulses.
- R5: Before each sector write the controller reads status. If bit 3 (the erase timer bit) is 1, it stops without setting the error flag, and that sector and all later ones stay not accepted.
- R6: A sector write has write-enable high, data 8'h30, and the address of sector i taken from bits [i*ADDR_W +: ADDR_W] of the list, with sectors handled in ascending i.
- R7: After each write the controller reads status. If bit 3 is 0, the sector's accepted bit is set. If it is 1, the error flag is set, the sector stays not accepted, and the queue stops.
- R8: Done is a single-cycle pulse in the last busy cycle, and busy is low in the cycle after it. The mask and error flag hold until the next accepted start.
- R9: A start while busy is ignored. A count above N_SEC is treated as N_SEC.
- R10: A bus request stays high, with address, write-enable and write data unchanged, until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, taken only when idle |
| sector_list_i | input | N_SEC*ADDR_W | Sector addresses; sector i in bits [i*ADDR_W +: ADDR_W] |
| sector_cnt_i | input | $clog2(N_SEC+1) | Number of sectors to add |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transfer address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge; read data valid in the same cycle |
| bus_rdata_i | input | 8 | Read data (status byte) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| drop_err_o | output | 1 | A data cycle may have been dropped, or the initial command was not confirmed |
| accepted_o | output | N_SEC | Per-sector accepted flags |

## Verification
The bench builds the block with N_SEC = 4 and ADDR_W = 8. It sweeps every count from 0 to 7, which covers the clamp above four. It also sweeps every timer-onset point across the full transfer sequence, all three confirmation behaviours (poll low, toggle, neither), and acknowledge latencies of 0 to 2 cycles. This small configuration covers every possible stop point: before a confirm, before a write, after a write, or none. The bench works out the expected mask, error flag and transfer counts arithmetically from the transfer index at which the modelled timer turns on.

// File: rtl/mse_pkg.sv
package mse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONF1 = 3'd1,
    ST_CONF2 = 3'd2,
    ST_PRE   = 3'd3,
    ST_WR    = 3'd4,
    ST_POST  = 3'd5,
    ST_FIN   = 3'd6
  } mse_state_e;

  localparam int unsigned STAT_W     = 8;
  localparam int unsigned BIT_POLL   = 7;
  localparam int unsigned BIT_TOGGLE = 6;
  localparam int unsigned BIT_TIMER  = 3;
  localparam logic [STAT_W-1:0] CONFIRM_BYTE = 8'h30;
endpackage

// File: rtl/mse_rst_sync.sv
module mse_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mse_status_eval.sv
module mse_status_eval
  import mse_pkg::*;
(
  input  logic [STAT_W-1:0] rd_now,
  input  logic [STAT_W-1:0] rd_prev,
  output logic              poll_busy,
  output logic              toggled,
  output logic              timer_on
);
  always_comb begin
    poll_busy = ~rd_now[BIT_POLL];
    toggled   = rd_now[BIT_TOGGLE] ^ rd_prev[BIT_TOGGLE];
    timer_on  = rd_now[BIT_TIMER];
  end
endmodule

// File: rtl/mse_sector_index.sv
module mse_sector_index #(
  parameter int unsigned N_SEC = 4,
  parameter int unsigned CNT_W = $clog2(N_SEC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] count_in,
  output logic [CNT_W-1:0] idx,
  output logic             is_last
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(N_SEC);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             en;

  always_comb begin
    idx_d = idx_q;
    lim_d = lim_q;
    en    = clr | adv;
    if (clr) begin
      idx_d = '0;
      lim_d = (count_in > MAX_CNT) ? MAX_CNT : count_in;
    end else if (adv) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      lim_q <= '0;
    end else if (en) begin
      idx_q <= idx_d;
      lim_q <= lim_d;
    end
  end

  assign idx     = idx_q;
  assign is_last = (idx_q + 1'b1) == lim_q;
endmodule

// File: rtl/mse_accept_mask.sv
module mse_accept_mask #(
  parameter int unsigned N_SEC = 4,
  parameter int unsigned CNT_W = $clog2(N_SEC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set,
  input  logic [CNT_W-1:0] set_idx,
  output logic [N_SEC-1:0] mask
);
  for (genvar g = 0; g < N_SEC; g++) begin : g_bit
    logic bit_q, bit_d, bit_en;

    always_comb begin
      bit_en = clr | (set && (set_idx == CNT_W'(g)));
      bit_d  = ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign mask[g] = bit_q;
  end
endmodule

// File: rtl/mse_erase_queue.sv
module mse_erase_queue
  import mse_pkg::*;
#(
  parameter int unsigned N_SEC  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = $clog2(N_SEC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [N_SEC*ADDR_W-1:0] sector_list_i,
  input  logic [CNT_W-1:0]        sector_cnt_i,
  output logic                    bus_req_o,
  output logic                    bus_we_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [STAT_W-1:0]       bus_wdata_o,
  input  logic                    bus_ack_i,
  input  logic [STAT_W-1:0]       bus_rdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    drop_err_o,
  output logic [N_SEC-1:0]        accepted_o
);
  localparam int unsigned IDX_W = (N_SEC > 1) ? $clog2(N_SEC) : 1;

  logic rst_n_s;
  mse_state_e state_q, state_d;
  logic [STAT_W-1:0] prev_q;
  logic err_q, err_d, err_en;
  logic xfer, idx_clr, idx_adv, mask_set, err_set, prev_ld;
  logic poll_busy, toggled, timer_on, is_last;
  logic [CNT_W-1:0] idx;
  logic [IDX_W-1:0] sel;

  mse_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  mse_status_eval u_eval (
    .rd_now(bus_rdata_i), .rd_prev(prev_q),
    .poll_busy(poll_busy), .toggled(toggled), .timer_on(timer_on)
  );

  mse_sector_index #(.N_SEC(N_SEC), .CNT_W(CNT_W)) u_idx (
    .clk(clk), .rst_n(rst_n_s), .clr(idx_clr), .adv(idx_adv),
    .count_in(sector_cnt_i), .idx(idx), .is_last(is_last)
  );

  mse_accept_mask #(.N_SEC(N_SEC), .CNT_W(CNT_W)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .clr(idx_clr), .set(mask_set),
    .set_idx(idx), .mask(accepted_o)
  );

  assign xfer = bus_req_o & bus_ack_i;
  assign sel  = idx[IDX_W-1:0];

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_clr  = 1'b0;
    idx_adv  = 1'b0;
    mask_set = 1'b0;
    err_set  = 1'b0;
    prev_ld  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        idx_clr = 1'b1;
        state_d = (sector_cnt_i == '0) ? ST_FIN : ST_CONF1;
      end
      ST_CONF1: if (xfer) begin
        prev_ld = 1'b1;
        state_d = poll_busy ? ST_PRE : ST_CONF2;
      end
      ST_CONF2: if (xfer) begin
        if (toggled) state_d = ST_PRE;
        else begin
          err_set = 1'b1;
          state_d = ST_FIN;
        end
      end
      ST_PRE: if (xfer) state_d = timer_on ? ST_FIN : ST_WR;
      ST_WR:  if (xfer) state_d = ST_POST;
      ST_POST: if (xfer) begin
        if (timer_on) begin
          err_set = 1'b1;
          state_d = ST_FIN;
        end else begin
          mask_set = 1'b1;
          if (is_last) state_d = ST_FIN;
          else begin
            idx_adv = 1'b1;
            state_d = ST_PRE;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_en = idx_clr | err_set;
    err_d  = err_set;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      prev_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (prev_ld) prev_q <= bus_rdata_i;
      if (err_en)  err_q  <= err_d;
    end
  end

  // Bus and status outputs
  always_comb begin
    bus_req_o   = (state_q == ST_CONF1) || (state_q == ST_CONF2) ||
                  (state_q == ST_PRE)   || (state_q == ST_WR)    ||
                  (state_q == ST_POST);
    bus_we_o    = (state_q == ST_WR);
    bus_wdata_o = bus_we_o ? CONFIRM_BYTE : '0;
    bus_addr_o  = sector_list_i[sel*ADDR_W +: ADDR_W];
    busy_o      = (state_q != ST_IDLE);
    done_o      = (state_q == ST_FIN);
    drop_err_o  = err_q;
  end
endmodule

// File: rtl/mse_erase_queue_chk.sv
module mse_erase_queue_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [7:0]        bus_wdata_o,
  input logic              bus_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              drop_err_o
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R6
  wr_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o) |-> (bus_wdata_o == 8'h30));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_req_o && !done_o));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_err_o) |-> $past(bus_req_o && bus_ack_i && !bus_we_o));

  // R8
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_req_o);
endmodule

bind mse_erase_queue mse_erase_queue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
  .busy_o(busy_o), .done_o(done_o), .drop_err_o(drop_err_o)
);

// File: tb/mse_erase_queue_tb.sv
module mse_erase_queue_tb;
  localparam int N_SEC  = 4;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [N_SEC*ADDR_W-1:0] sector_list_i = '0;
  logic [CNT_W-1:0] sector_cnt_i = '0;
  logic bus_req_o, bus_we_o, busy_o, done_o, drop_err_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [7:0] bus_wdata_o;
  logic bus_ack_i = 1'b0;
  logic [7:0] bus_rdata_i = '0;
  logic [N_SEC-1:0] accepted_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int dev_mode = 0, dev_t = 0, dev_lat = 0;
  int tx_cnt = 0, wr_cnt = 0, wait_cnt = 0;
  logic dev_tog = 1'b0;

  always #2 clk = ~clk;

  mse_erase_queue #(.N_SEC(N_SEC), .ADDR_W(ADDR_W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sec_addr(input int run, input int i);
    return 8'((run * 5 + i * 37 + 3) & 255);
  endfunction

  int cur_run = 0;

  // Device model, driven at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "R8 watchdog", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    if (bus_ack_i) begin
      bus_ack_i = 1'b0;
    end else if (bus_req_o) begin
      if (wait_cnt >= dev_lat) begin
        wait_cnt = 0;
        if (bus_we_o) begin
          check(bus_addr_o == sec_addr(cur_run, wr_cnt), "R6 addr", bus_addr_o, sec_addr(cur_run, wr_cnt));
          check(bus_wdata_o == 8'h30, "R6 data", bus_wdata_o, 8'h30);
          wr_cnt++;
        end else begin
          if (dev_mode == 1) dev_tog = ~dev_tog;
        end
        bus_rdata_i = {(dev_mode != 0), (dev_mode == 1) ? dev_tog : 1'b0, 2'b00,
                       (tx_cnt >= dev_t), 3'b000};
        tx_cnt++;
        bus_ack_i = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic run_one(input int run, input int mode, input int t, input int n);
    int neff, c, e_tx, e_wr, e_err;
    logic [N_SEC-1:0] e_mask;
    bit got_done;
    neff = (n > N_SEC) ? N_SEC : n;
    c = (mode == 0) ? 1 : 2;
    e_mask = '0; e_err = 0; e_wr = 0; e_tx = 0;
    if (neff == 0) e_tx = 0;
    else if (mode == 2) begin e_tx = 2; e_err = 1; end
    else begin
      e_tx = c + 3 * neff;
      for (int i = 0; i < neff; i++) begin
        if (c + 3 * i >= t) begin e_tx = c + 3 * i + 1; break; end
        e_wr++;
        if (c + 3 * i + 2 >= t) begin e_err = 1; e_tx = c + 3 * i + 3; break; end
        e_mask[i] = 1'b1;
      end
    end
    @(negedge clk);
    cur_run = run; dev_mode = mode; dev_t = t; dev_lat = run % 3;
    tx_cnt = 0; wr_cnt = 0; wait_cnt = 0; dev_tog = 1'b0;
    for (int i = 0; i < N_SEC; i++) sector_list_i[i*ADDR_W +: ADDR_W] = sec_addr(run, i);
    sector_cnt_i = CNT_W'(n);
    start_i = 1'b1;
    got_done = 1'b0;
    for (int k = 0; k < 300 && !got_done; k++) begin
      @(negedge clk);
      start_i = (k == 2 && n > 0);  // R9: restart attempt while busy
      if (done_o) got_done = 1'b1;
    end
    start_i = 1'b0;
    check(got_done, "R8 done seen", got_done, 1);
    check(accepted_o == e_mask, (e_err != 0) ? "R7 mask" : "R5 mask", accepted_o, e_mask);
    check(drop_err_o == e_err[0], (mode == 2) ? "R4 err" : "R7 err", drop_err_o, e_err);
    check(tx_cnt == e_tx, (n == 0) ? "R2 transfers" : (mode == 0) ? "R3 transfers" : "R9 transfers", tx_cnt, e_tx);
    check(wr_cnt == e_wr, "R5 writes", wr_cnt, e_wr);
    @(negedge clk);
    check(!done_o && !busy_o, "R8 pulse end", done_o, 0);
    check(accepted_o == e_mask && drop_err_o == e_err[0], "R8 hold", accepted_o, e_mask);
  endtask

  initial begin
    int run;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !bus_req_o, "R1 idle in reset", busy_o, 0);
    check(accepted_o == '0 && !drop_err_o, "R1 clear in reset", accepted_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !bus_req_o && !drop_err_o && accepted_o == '0,
          "R1 after reset", busy_o, 0);
    run = 0;
    for (int mode = 0; mode < 3; mode++)
      for (int n = 0; n < 8; n++)
        for (int t = 0; t < 17; t++) begin
          run_one(run, mode, t, n);
          run++;
        end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule